// File: doc/BRIEF.md
# Context Memory Compare-Swap Access Port

This block gives a host a register-mapped window into a shared context memory made of numbered sites, each holding a fixed number of 16-bit words. The same memory is also used by an internal sequencer through its own request/grant port. The host picks a word by writing a word offset within a site and a site number. After that, every access to the window register reads or writes that word. Window writes can be limited to single bytes.

The host can also update a word atomically while the sequencer keeps running. It loads an expected value and then a replacement value, and the write of the replacement value starts a hardware compare-and-swap. The engine reads the target word, checks its two per-byte parity bits, and compares the word with the expected value. It writes the replacement only when the word matches and the parity is clean. For the whole operation the sequencer is held off the memory. Software polls a status register for a done flag. Next to the done flag sit an error flag for a parity failure and a win flag for a successful swap.

A size register reports how large the command and device context memories are. The value is chosen by a configuration input.

Top module: `ctx_cas_port`

## Requirements
- R1: The selected word's absolute memory address is SITE_BASE + site * 2^SITE_AW + offset. The offset register is at address 0 and keeps its low SITE_AW bits. The site register is at address 1 and keeps its low SITE_PW bits. The sequencer port reaches the same word at that absolute address.
- R2: The host register addresses are: window 2, expected value 3, replacement value 4, status 5, size 6. A read pulse yields `reg_rvalid` with the data exactly one cycle later. Window reads return the selected word, and window writes store to it.
- R3: On a window write, `reg_be[0]` enables bits 7:0 and `reg_be[1]` enables bits 15:8. A byte whose enable is low keeps its stored value.
- R4: Status holds bit0 done, bit1 error and bit2 win. Writing the replacement register while idle starts a swap and clears all three bits. Done sets within two cycles.
- R5: If the target word equals the expected value and the parity is clean, the word becomes the replacement value and the status reads done=1, error=0, win=1.
- R6: If the word differs from the expected value, memory is unchanged and the status reads done=1, error=0, win=0.
- R7: Each byte is stored with an even-parity bit. While `inj_perr` is high, a write stores inverted parity. A parity error on the swap's read gives done=1, error=1, win=0, and no write takes place.
- R8: From the cycle after the swap starts until it completes, `seq_gnt` stays low. A pending sequencer request is granted after that.
- R9: The size register reads {device KiB[15:8], command KiB[7:0]}. It is 0x0840 when `cfg_large` is 1 and 0x0420 when it is 0.
- R10: While a swap is running, window writes and writes to the expected or replacement register are ignored.
- R11: After reset the status reads 0 and `reg_rvalid` is low. With the host idle, a sequencer request is granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_large | input | 1 | Selects the large context memory sizes |
| inj_perr | input | 1 | Stores inverted parity on writes (fault injection) |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Host register address |
| reg_be | input | 2 | Byte enables for window writes |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data |
| reg_rvalid | output | 1 | Read data valid |
| seq_req | input | 1 | Sequencer memory request |
| seq_we | input | 1 | Sequencer write (1) or read (0) |
| seq_addr | input | MEM_AW | Sequencer absolute word address |
| seq_wdata | input | 16 | Sequencer write data |
| seq_gnt | output | 1 | Sequencer request accepted this cycle |
| seq_rvalid | output | 1 | Sequencer read data valid |
| seq_rdata | output | 16 | Sequencer read data |

## Verification
If the engine's state is wrong, the status register shows it at once. Done either never sets within two cycles of the start or sets with an impossible error/win pair. The final word, read through the window one cycle after the request, exposes a lost or spurious write. If the lock is broken, `seq_gnt` rises during the read-to-write gap, and a sequencer write placed there would be overwritten or would flip the swap's outcome. A wrong address or byte lane shows up as a mismatch between the window and the sequencer's view of the same absolute word.

// File: rtl/ctx_cas_pkg.sv
package ctx_cas_pkg;
  localparam int DW    = 16;
  localparam int LANES = DW / 8;

  localparam logic [2:0] RA_OFFS = 3'd0;
  localparam logic [2:0] RA_SITE = 3'd1;
  localparam logic [2:0] RA_WIN  = 3'd2;
  localparam logic [2:0] RA_OLD  = 3'd3;
  localparam logic [2:0] RA_NEW  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
  localparam logic [2:0] RA_SIZE = 3'd6;

  localparam logic [7:0] CMD_KIB_LG = 8'd64;
  localparam logic [7:0] CMD_KIB_SM = 8'd32;
  localparam logic [7:0] DEV_KIB_LG = 8'd8;
  localparam logic [7:0] DEV_KIB_SM = 8'd4;

  typedef struct packed {
    logic win;
    logic err;
    logic done;
  } cas_stat_t;

  typedef enum logic [1:0] {CS_IDLE, CS_READ, CS_CMP} cas_state_e;

  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/ctx_par_mem.sv
module ctx_par_mem
  import ctx_cas_pkg::*;
#(
  parameter int DEPTH = 144,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             inj,
  output logic [DW-1:0]    rdata,
  output logic             perr
);
  logic [LANES-1:0] lane_bad;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [8:0] ram [DEPTH];
    logic [8:0] q;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[l])
          ram[addr] <= {even_par(wdata[8*l +: 8]) ^ inj, wdata[8*l +: 8]};
        q <= ram[addr];
      end
    end
    assign rdata[8*l +: 8] = q[7:0];
    assign lane_bad[l]     = ^q;
  end

  assign perr = |lane_bad;
endmodule

// File: rtl/ctx_cas_fsm.sv
module ctx_cas_fsm
  import ctx_cas_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_perr,
  output logic          busy,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output cas_stat_t     stat
);
  cas_state_e    state;
  logic [AW-1:0] addr_q;
  logic          match;

  assign match     = !rd_perr && (rd_data == old_val);
  assign busy      = (state != CS_IDLE);
  assign mem_we    = (state == CS_CMP) && match;
  assign mem_en    = (state == CS_READ) || mem_we;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CS_IDLE;
      addr_q <= '0;
    end else begin
      case (state)
        CS_IDLE: if (start) begin
          state  <= CS_READ;
          addr_q <= tgt_addr;
        end
        CS_READ: state <= CS_CMP;
        default: state <= CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else if (start && state == CS_IDLE) begin
      stat <= '0;
    end else if (state == CS_CMP) begin
      stat.done <= 1'b1;
      stat.err  <= rd_perr;
      stat.win  <= match;
    end
  end

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state == CS_IDLE) |=> (!stat.done && state == CS_READ));
  // R4
  done_after_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat.done) |-> $past(state) == CS_CMP);
  // R5
  write_means_win_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (stat.win && stat.done && !stat.err));
endmodule

// File: rtl/ctx_cas_port.sv
module ctx_cas_port
  import ctx_cas_pkg::*;
#(
  parameter int SITE_PW   = 4,
  parameter int SITE_AW   = 3,
  parameter int SITE_BASE = 16,
  localparam int MEM_DEPTH = SITE_BASE + (1 << (SITE_AW + SITE_PW)),
  localparam int MEM_AW    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_large,
  input  logic              inj_perr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [1:0]        reg_be,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic              seq_req,
  input  logic              seq_we,
  input  logic [MEM_AW-1:0] seq_addr,
  input  logic [15:0]       seq_wdata,
  output logic              seq_gnt,
  output logic              seq_rvalid,
  output logic [15:0]       seq_rdata
);
  logic [SITE_AW-1:0] offs_q;
  logic [SITE_PW-1:0] site_q;
  logic [DW-1:0]      old_q, new_q, rd_reg_q;
  logic               win_q;
  logic [MEM_AW-1:0]  host_addr;
  logic               c_busy, c_en, c_we, start, host_win;
  logic [MEM_AW-1:0]  c_addr;
  logic [DW-1:0]      c_wdata;
  cas_stat_t          stat;
  logic               m_en, m_we, m_perr;
  logic [LANES-1:0]   m_be;
  logic [MEM_AW-1:0]  m_addr;
  logic [DW-1:0]      m_wdata, m_rdata;

  assign host_addr = MEM_AW'(SITE_BASE) + MEM_AW'({site_q, offs_q});
  assign start     = reg_wr && reg_addr == RA_NEW && !c_busy;
  assign host_win  = (reg_wr || reg_rd) && reg_addr == RA_WIN && !c_busy;

  // host registers
  always_ff @(posedge clk) begin
    if (rst) begin
      offs_q <= '0;
      site_q <= '0;
      old_q  <= '0;
      new_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_OFFS: offs_q <= reg_wdata[SITE_AW-1:0];
        RA_SITE: site_q <= reg_wdata[SITE_PW-1:0];
        RA_OLD:  if (!c_busy) old_q <= reg_wdata;
        RA_NEW:  if (!c_busy) new_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  // memory port arbitration: swap engine, then host window, then sequencer
  always_comb begin
    m_en    = 1'b0;
    m_we    = 1'b0;
    m_be    = '1;
    m_addr  = host_addr;
    m_wdata = reg_wdata;
    seq_gnt = 1'b0;
    if (c_en) begin
      m_en    = 1'b1;
      m_we    = c_we;
      m_addr  = c_addr;
      m_wdata = c_wdata;
    end else if (host_win) begin
      m_en = 1'b1;
      m_we = reg_wr;
      m_be = reg_be;
    end else if (seq_req && !c_busy) begin
      seq_gnt = 1'b1;
      m_en    = 1'b1;
      m_we    = seq_we;
      m_addr  = seq_addr;
      m_wdata = seq_wdata;
    end
  end

  ctx_par_mem #(.DEPTH(MEM_DEPTH), .AW(MEM_AW)) u_mem (
    .clk(clk), .en(m_en), .we(m_we), .be(m_be), .addr(m_addr),
    .wdata(m_wdata), .inj(inj_perr), .rdata(m_rdata), .perr(m_perr)
  );

  ctx_cas_fsm #(.AW(MEM_AW)) u_cas (
    .clk(clk), .rst(rst), .start(start), .tgt_addr(host_addr),
    .old_val(old_q), .new_val(new_q), .rd_data(m_rdata), .rd_perr(m_perr),
    .busy(c_busy), .mem_en(c_en), .mem_we(c_we), .mem_addr(c_addr),
    .mem_wdata(c_wdata), .stat(stat)
  );

  // read path
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      win_q      <= 1'b0;
      rd_reg_q   <= '0;
      seq_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      win_q      <= reg_rd && host_win;
      seq_rvalid <= seq_gnt && !seq_we;
      case (reg_addr)
        RA_OFFS: rd_reg_q <= DW'(offs_q);
        RA_SITE: rd_reg_q <= DW'(site_q);
        RA_OLD:  rd_reg_q <= old_q;
        RA_NEW:  rd_reg_q <= new_q;
        RA_STAT: rd_reg_q <= DW'(stat);
        RA_SIZE: rd_reg_q <= cfg_large ? {DEV_KIB_LG, CMD_KIB_LG}
                                       : {DEV_KIB_SM, CMD_KIB_SM};
        default: rd_reg_q <= '0;
      endcase
    end
  end

  assign reg_rdata = win_q ? m_rdata : rd_reg_q;
  assign seq_rdata = m_rdata;

  // R8
  seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    c_busy |-> !seq_gnt);
  // R2
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  // R7
  err_no_win_chk: assert property (@(posedge clk) disable iff (rst)
    stat.err |-> (stat.done && !stat.win));
endmodule

// File: tb/test_ctx_cas_port.sv
module test_ctx_cas_port;
  localparam int AW = 8;
  localparam int BASE = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_large = 1'b0, inj_perr = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [1:0] reg_be = 2'b11;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid;
  logic seq_req = 1'b0, seq_we = 1'b0;
  logic [AW-1:0] seq_addr = '0;
  logic [15:0] seq_wdata = '0, seq_rdata;
  logic seq_gnt, seq_rvalid;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  ctx_cas_port i_ctx_cas_port (
    .clk(clk), .rst(rst), .cfg_large(cfg_large), .inj_perr(inj_perr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .seq_req(seq_req), .seq_we(seq_we), .seq_addr(seq_addr),
    .seq_wdata(seq_wdata), .seq_gnt(seq_gnt), .seq_rvalid(seq_rvalid),
    .seq_rdata(seq_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b11;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    if (!reg_rvalid) chk("R2 rvalid", 16'(reg_rvalid), 16'd1);
    reg_rd = 1'b0;
  endtask

  task automatic sel(input int site, input int offs);
    wr(3'd1, 16'(site));
    wr(3'd0, 16'(offs));
  endtask

  task automatic seq_op(input logic we, input int a, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    seq_req = 1'b1; seq_we = we; seq_addr = AW'(a); seq_wdata = d;
    while (!seq_gnt) @(negedge clk);
    @(negedge clk);
    q = seq_rdata;
    seq_req = 1'b0;
  endtask

  task automatic wait_done(output logic [15:0] st);
    for (int i = 0; i < 10; i++) begin
      rd(3'd5, st);
      if (st[0]) return;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R11 rvalid after reset", 16'(reg_rvalid), 16'd0);
    rd(3'd5, v);
    chk("R11 status after reset", v, 16'h0000);
    @(negedge clk);
    seq_req = 1'b1; seq_we = 1'b0; seq_addr = AW'(BASE);
    #1 chk("R11 idle grant", 16'(seq_gnt), 16'd1);
    @(negedge clk); seq_req = 1'b0;
  endtask

  task automatic t_addr;
    logic [15:0] v;
    sel(0, 0); wr(3'd2, 16'h1000);
    sel(1, 0); wr(3'd2, 16'h1100);
    sel(0, 1); wr(3'd2, 16'h1001);
    sel(15, 7); wr(3'd2, 16'h1F07);
    sel(0, 0); rd(3'd2, v); chk("R2 window s0o0", v, 16'h1000);
    sel(1, 0); rd(3'd2, v); chk("R1 window s1o0", v, 16'h1100);
    sel(0, 1); rd(3'd2, v); chk("R1 window s0o1", v, 16'h1001);
    seq_op(1'b0, BASE + 8, 16'h0, v);   chk("R1 seq view s1o0", v, 16'h1100);
    seq_op(1'b0, BASE + 127, 16'h0, v); chk("R1 seq view s15o7", v, 16'h1F07);
    seq_op(1'b1, BASE + 9, 16'hBEEF, v);
    sel(1, 1); rd(3'd2, v); chk("R1 seq write seen in window", v, 16'hBEEF);
  endtask

  task automatic t_bytes;
    logic [15:0] v;
    sel(3, 2);
    wr(3'd2, 16'hA55A);
    wr(3'd2, 16'h3CFF, 2'b10);
    rd(3'd2, v); chk("R3 upper byte only", v, 16'h3C5A);
    wr(3'd2, 16'hFF77, 2'b01);
    rd(3'd2, v); chk("R3 lower byte only", v, 16'h3C77);
  endtask

  task automatic t_cas_win;
    logic [15:0] v;
    sel(4, 0); wr(3'd2, 16'h1234);
    wr(3'd3, 16'h1234);
    wr(3'd4, 16'h5678);
    rd(3'd5, v); chk("R4 status cleared at start", v, 16'h0000);
    wait_done(v); chk("R5 status win", v, 16'h0005);
    rd(3'd2, v); chk("R5 word swapped", v, 16'h5678);
  endtask

  task automatic t_cas_lose;
    logic [15:0] v;
    sel(4, 1); wr(3'd2, 16'h0F0F);
    wr(3'd3, 16'h0F0E);
    wr(3'd4, 16'h9999);
    wait_done(v); chk("R6 status lose", v, 16'h0001);
    rd(3'd2, v); chk("R6 word unchanged", v, 16'h0F0F);
  endtask

  task automatic t_cas_perr;
    logic [15:0] v;
    sel(2, 3);
    inj_perr = 1'b1; wr(3'd2, 16'h1111); inj_perr = 1'b0;
    wr(3'd3, 16'h1111);
    wr(3'd4, 16'h2222);
    wait_done(v); chk("R7 status parity error", v, 16'h0003);
    rd(3'd2, v); chk("R7 no write on error", v, 16'h1111);
  endtask

  task automatic t_lock;
    logic [15:0] v;
    sel(5, 5); wr(3'd2, 16'hC0C0);
    wr(3'd3, 16'hC0C0);
    wr(3'd4, 16'hD0D0);
    seq_req = 1'b1; seq_we = 1'b1; seq_addr = AW'(BASE + 45); seq_wdata = 16'hE0E0;
    chk("R8 held in read", 16'(seq_gnt), 16'd0);
    @(negedge clk); chk("R8 held in compare", 16'(seq_gnt), 16'd0);
    @(negedge clk); chk("R8 granted after swap", 16'(seq_gnt), 16'd1);
    @(negedge clk); seq_req = 1'b0; seq_we = 1'b0;
    wait_done(v); chk("R8 swap saw pre-sequencer value", v, 16'h0005);
    rd(3'd2, v); chk("R8 sequencer write lands after swap", v, 16'hE0E0);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] v;
    sel(6, 0); wr(3'd2, 16'hAAAA);
    wr(3'd3, 16'hAAAA);
    wr(3'd4, 16'hBBBB);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h7777;
    @(negedge clk); reg_addr = 3'd3; reg_wdata = 16'h4444;
    @(negedge clk); reg_wr = 1'b0;
    wait_done(v); chk("R10 swap completes", v, 16'h0005);
    rd(3'd2, v); chk("R10 window write ignored", v, 16'hBBBB);
    rd(3'd3, v); chk("R10 expected write ignored", v, 16'hAAAA);
  endtask

  task automatic t_size;
    logic [15:0] v;
    cfg_large = 1'b1; rd(3'd6, v); chk("R9 large size", v, 16'h0840);
    cfg_large = 1'b0; rd(3'd6, v); chk("R9 small size", v, 16'h0420);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_addr();
    t_bytes();
    t_cas_win();
    t_cas_lose();
    t_cas_perr();
    t_lock();
    t_busy_ignore();
    t_size();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule